// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port on a simple byte-wide memory-mapped bus. Each pin has its own direction bit. Pins in output mode drive the pad from an output latch. Pins in input mode are sampled through a two-flop synchronizer.

Port data is reached through a 256-word data window. The address of each access doubles as a pin mask: word-address bits [9:2] select which pins a write may change and which pins a read reports. Software can therefore set or clear one pin, or any group of pins, in a single bus write, with no read-modify-write sequence and no lock.

The direction register sits just above the data window. All other offsets are left undecoded, including the interrupt configuration offsets, which belong to a companion block.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is high and in the cycle after it, the direction register, the output latch, `pad_oe`, `pad_out` and `bus_rdata` are all zero.
- R2: A write to offset 0x400 loads the direction register (bit n = 1 makes pin n an output), and a read of 0x400 returns it.
- R3: A write with an offset below 0x400 uses offset bits [9:2] as a pin mask. It updates the output latch only where the mask bit is 1, and all other latch bits keep their values.
- R4: A data write has no effect on the latch bit of a pin that is in input mode. When that pin is later switched to output, it drives the latch value it held before the ignored write.
- R5: A data read returns 0 in every bit whose mask bit (offset bit n+2) is 0.
- R6: For an input pin, a data read returns the pad value through two synchronizer flops. A pad change driven before clock edge k is seen by a read request sampled at edge k+2 and not by requests sampled at edges k or k+1.
- R7: For an output pin, a data read returns the output latch bit, whatever the pad input value is.
- R8: `pad_oe` always equals the direction register, and `pad_out` always equals the output latch.
- R9: An access is undecoded if its offset has bits [1:0] not zero, or if it is neither in 0x000–0x3FC nor equal to 0x400. An undecoded read returns 0, and an undecoded write changes no state.
- R10: A read request sampled at a clock edge produces `bus_rvalid` = 1 with its data right after that edge. `bus_rvalid` is 0 after any edge at which no read request was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid pulse |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |

## Verification
The hardest case to reach is a pad edge racing a read through the synchronizer, because the read must land on exactly the cycles before and after the second flop updates. The bench changes the pads on the same falling edge that it issues the first of three back-to-back masked reads. It then expects the old value twice and the new value on the third read. It also writes ones to pins that are still inputs and then turns them into outputs, so that a latch that wrongly accepted the write would show up on `pad_out`.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    localparam int GPIO_PINS   = 8;
    localparam int GPIO_AW     = 12;
    localparam int MASK_LSB    = 2;
    localparam int MASK_MSB    = MASK_LSB + GPIO_PINS - 1;
    localparam logic [GPIO_AW-1:0] DIR_OFFSET = GPIO_AW'(1) << (GPIO_PINS + MASK_LSB);

    typedef logic [GPIO_PINS-1:0] pins_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
        pins_t    mask;
        pins_t    wdata;
    } access_t;

    function automatic reg_sel_e classify(input logic [GPIO_AW-1:0] addr);
        reg_sel_e s;
        s = SEL_NONE;
        if (addr[MASK_LSB-1:0] == '0) begin
            if (addr[GPIO_AW-1:MASK_MSB+1] == '0)
                s = SEL_DATA;
            else if (addr == DIR_OFFSET)
                s = SEL_DIR;
        end
        return s;
    endfunction

    function automatic pins_t read_value(input access_t a, input pins_t dir,
                                         input pins_t latch, input pins_t synced);
        pins_t v;
        case (a.sel)
            SEL_DATA: v = ((dir & latch) | (~dir & synced)) & a.mask;
            SEL_DIR:  v = dir;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
(
    input  logic               req,
    input  logic               we,
    input  logic [GPIO_AW-1:0] addr,
    input  pins_t              wdata,
    output access_t            acc
);
    reg_sel_e sel;

    always_comb begin
        sel       = classify(addr);
        acc.rd    = req & ~we;
        acc.wr    = req & we;
        acc.sel   = sel;
        acc.wdata = wdata;
        case (sel)
            SEL_DATA: acc.mask = addr[MASK_MSB:MASK_LSB];
            SEL_DIR:  acc.mask = '1;
            default:  acc.mask = '0;
        endcase
    end

    // R9
    always_comb begin
        if (addr[1:0] != 2'b00)
            undecoded_misaligned_chk: assert (sel == SEL_NONE);
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_mask_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pad_in,
    output pins_t synced
);
    pins_t chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= pad_in;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];

    // R6
    sync_two_stage_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst, 2) |-> synced == $past(pad_in, 2));
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
    import gpio_mask_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    output pins_t   dir,
    output pins_t   latch
);
    logic  dir_wr;
    logic  data_wr;
    pins_t upd;

    assign dir_wr  = acc.wr && (acc.sel == SEL_DIR);
    assign data_wr = acc.wr && (acc.sel == SEL_DATA);

    generate
        for (genvar i = 0; i < GPIO_PINS; i++) begin : g_pin
            assign upd[i] = data_wr & acc.mask[i] & dir[i];

            always_ff @(posedge clk) begin
                if (rst) begin
                    dir[i]   <= 1'b0;
                    latch[i] <= 1'b0;
                end else begin
                    if (dir_wr)
                        dir[i] <= acc.wdata[i];
                    if (upd[i])
                        latch[i] <= acc.wdata[i];
                end
            end
        end
    endgenerate

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dir == '0 && latch == '0));

    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.sel == SEL_DIR) |=> dir == $past(acc.wdata));

    // R3
    unmasked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.sel == SEL_DATA) |=> ((latch ^ $past(latch)) & ~$past(acc.mask)) == '0);

    // R4
    input_pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.sel == SEL_DATA) |=> ((latch ^ $past(latch)) & ~$past(dir)) == '0);

    // R9
    undecoded_write_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.sel == SEL_NONE) |=> ($stable(latch) && $stable(dir)));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [GPIO_AW-1:0] bus_addr,
    input  logic [GPIO_PINS-1:0] bus_wdata,
    output logic [GPIO_PINS-1:0] bus_rdata,
    output logic               bus_rvalid,
    input  logic [GPIO_PINS-1:0] pad_in,
    output logic [GPIO_PINS-1:0] pad_out,
    output logic [GPIO_PINS-1:0] pad_oe
);
    access_t acc;
    pins_t   dir;
    pins_t   latch;
    pins_t   synced;

    gpio_addr_decode u_dec (
        .req   (bus_req),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .acc   (acc)
    );

    gpio_in_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .synced (synced)
    );

    gpio_out_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .dir   (dir),
        .latch (latch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= acc.rd;
            if (acc.rd)
                bus_rdata <= read_value(acc, dir, latch, synced);
        end
    end

    assign pad_oe  = dir;
    assign pad_out = latch;

    // R5
    unmasked_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        acc.rd |=> (bus_rdata & ~$past(acc.mask)) == '0);

    // R9
    undecoded_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.sel == SEL_NONE) |=> bus_rdata == '0);

    // R10
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_rvalid == !$past(bus_we));

    // R10
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !bus_rvalid);

    // R1
    reset_outputs_chk: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0 && !bus_rvalid));
endmodule

// File: tb/gpio_mask_port_test.sv
module gpio_mask_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sb [$];

    gpio_mask_port uut (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] e, input string tag);
        exp_t item;
        item.exp = e; item.tag = tag;
        sb.push_back(item);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    // monitor: pops expected items as read data appears
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (sb.size() == 0) begin
                checks++; failures++;
                $display("FAIL R10 actual=rvalid expected=no read pending");
            end else begin
                exp_t item;
                item = sb.pop_front();
                check(item.tag, bus_rdata, item.exp);
            end
        end
    end

    initial begin
        #(20000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state while reset is high
        check("R1 pad_oe in reset", pad_oe, 8'h00);
        check("R1 pad_out in reset", pad_out, 8'h00);
        check("R1 rdata in reset", bus_rdata, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(12'h400, 8'h00, "R1 direction after reset");

        // R4: writes to pins that are all inputs
        wr(12'h3FC, 8'hFF);
        check("R4 pad_out after write to inputs", pad_out, 8'h00);

        // R2 / R8: low nibble becomes outputs
        wr(12'h400, 8'h0F);
        check("R2 R8 pad_oe follows direction", pad_oe, 8'h0F);
        check("R4 latch untouched by earlier write", pad_out, 8'h00);
        rd(12'h400, 8'h0F, "R2 direction readback");

        // R3: mask pins 0 and 2 only
        wr(12'h014, 8'hFF);
        check("R3 masked write pins 0 and 2", pad_out, 8'h05);

        // R3 / R4: full mask, inputs (4..7) ignored
        wr(12'h3FC, 8'hAA);
        check("R3 R4 full-mask write", pad_out, 8'h0A);

        // R3: single-pin clear of pin 1 (offset 1 << 3)
        wr(12'h008, 8'h00);
        check("R3 single pin clear", pad_out, 8'h08);

        // R6 / R7: mixed read
        pad_in = 8'h5C;
        @(negedge clk); @(negedge clk);
        rd(12'h3FC, 8'h58, "R6 R7 mixed full read");
        rd(12'h0C0, 8'h10, "R5 unmasked bits read zero");
        rd(12'h03C, 8'h08, "R7 output pins read latch not pad");

        // R6: pad change racing back-to-back reads
        pad_in = 8'hF0;
        rd(12'h3C0, 8'h50, "R6 edge k read old");
        rd(12'h3C0, 8'h50, "R6 edge k+1 read old");
        rd(12'h3C0, 8'hF0, "R6 edge k+2 read new");

        // R9: undecoded offsets
        wr(12'h404, 8'hFF);
        wr(12'h800, 8'hFF);
        wr(12'h401, 8'hFF);
        wr(12'h015, 8'hFF);
        check("R9 pad_oe after undecoded writes", pad_oe, 8'h0F);
        check("R9 pad_out after undecoded writes", pad_out, 8'h08);
        rd(12'h404, 8'h00, "R9 undecoded read 0x404");
        rd(12'h3FE, 8'h00, "R9 misaligned read");
        rd(12'h400, 8'h0F, "R9 direction kept");

        // R4: switching pins to output shows the pre-ignore latch value
        wr(12'h400, 8'hFF);
        check("R4 new outputs keep old latch", pad_out, 8'h08);
        wr(12'h3FC, 8'hA5);
        check("R8 pad_out after full write", pad_out, 8'hA5);
        rd(12'h3FC, 8'hA5, "R7 read all outputs");

        // R10: write then idle cycles produce no read data
        wr(12'h3FC, 8'h3C);
        @(negedge clk); @(negedge clk);
        check("R10 no pending reads", 8'(sb.size()), 8'h00);
        check("R10 rvalid low when idle", {7'b0, bus_rvalid}, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule